// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Bank

This block holds a small set of binary lock flags that two independent agents, a left port and a right port, share for mutual exclusion. Each port can pick one flag per cycle with an index, and may write a single data bit to it or just read it. An agent asks for a lock by writing 0 to a flag. It then reads the flag back: a 0 means it holds the lock and a 1 means it does not. It gives the lock up by writing 1. Ownership is settled in hardware, so two agents that ask at the same moment can never both come away holding the lock.

Each flag is a small state machine with five states. FREE means nobody holds the flag. LEFT_OWN and RIGHT_OWN mean one side holds it. LEFT_OWN_RPEND and RIGHT_OWN_LPEND mean one side holds it while the other side has a request queued. The transitions are:
- claim: FREE goes to LEFT_OWN or RIGHT_OWN.
- tie: FREE goes to LEFT_OWN_RPEND when both sides ask in the same cycle.
- queue: an owned state goes to its pending variant when the other side asks.
- release: an owned state goes to FREE.
- handover: a pending state goes to the other side's owned state when the owner releases. Release while the other side asks in the same cycle is also a handover.
- cancel: a pending state goes back to its plain owned state when the waiting side writes 1.
- dual exit: a pending state goes to FREE when both sides write 1 together.

A write takes effect at the next rising clock edge. A read reflects the state as it stands during the current cycle.

Top module: `sem_bank`

## Requirements
- R1: A port whose select input is low takes no part in any operation, whatever its write inputs carry, and its read output is 1.
- R2: A selected write of data 0 (a request) to a FREE flag makes that port the owner from the next cycle on. A selected read by the owner returns 0.
- R3: A selected read returns 1 to a port that does not own the indexed flag. This includes both ports when the flag is FREE.
- R4: A selected write of data 1 (a release) by the owner frees the flag, unless the other side has a request pending or asks in that same cycle.
- R5: A release written by a port that neither owns nor waits on the flag has no effect. The owner keeps the flag until it releases it.
- R6: When both ports request the same FREE flag in the same cycle, the left port becomes owner and the right port's request becomes pending.
- R7: A pending request is granted automatically in the cycle after the owner releases. This works in both directions.
- R8: A release written by the waiting port cancels its pending request, so a later release by the owner leaves the flag FREE.
- R9: No flag is ever owned by both ports at once.
- R10: Reset, which is synchronous and active high, frees all eight flags and clears every pending request.
- R11: The eight flags, selected by the 3-bit index values 0 to 7, are independent. An operation on one flag leaves every other flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lft_sel | input | 1 | Left port semaphore select |
| lft_idx | input | 3 | Left port flag index |
| lft_wr | input | 1 | Left port write strobe |
| lft_wdata | input | 1 | Left port write bit (0 request, 1 release) |
| lft_rdata | output | 1 | Left port read bit (0 = owned by left) |
| rgt_sel | input | 1 | Right port semaphore select |
| rgt_idx | input | 3 | Right port flag index |
| rgt_wr | input | 1 | Right port write strobe |
| rgt_wdata | input | 1 | Right port write bit (0 request, 1 release) |
| rgt_rdata | output | 1 | Right port read bit (0 = owned by right) |

## Verification
The assertions check a set of per-flag properties on every cycle:
- mutual exclusion;
- ownership persisting until the owner releases;
- the left-wins tie rule;
- handover of a pending request on release;
- cancellation of a pending request;
- the read bit matching ownership;
- the cleared state after reset.

Some behaviour shows only at the ports across several cycles, and the bench's scenarios cover it. These scenarios include:
- ignored writes from a deselected port;
- a cancelled request that must not be granted later;
- reset discarding a queued request;
- all eight flags held in a mixed pattern at once.

// File: rtl/sem_pkg.sv
package sem_pkg;
    localparam int SEM_FLAGS = 8;

    typedef enum logic [2:0] {
        FREE            = 3'd0,
        LEFT_OWN        = 3'd1,
        RIGHT_OWN       = 3'd2,
        LEFT_OWN_RPEND  = 3'd3,
        RIGHT_OWN_LPEND = 3'd4
    } flag_state_t;
endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
    parameter int NUM_FLAGS = 8,
    localparam int IW = $clog2(NUM_FLAGS)
) (
    input  logic                 sel,
    input  logic [IW-1:0]        idx,
    input  logic                 wr,
    input  logic                 wdata,
    output logic [NUM_FLAGS-1:0] req,
    output logic [NUM_FLAGS-1:0] rel
);
    for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_dec
        logic hit;
        assign hit    = sel && wr && (idx == IW'(k));
        assign req[k] = hit && !wdata;
        assign rel[k] = hit && wdata;
    end
endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lreq,
    input  logic lrel,
    input  logic rreq,
    input  logic rrel,
    output logic own_l,
    output logic own_r,
    output logic pend_l,
    output logic pend_r
);
    flag_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= FREE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FREE: begin
                if (lreq)      state_d = rreq ? LEFT_OWN_RPEND : LEFT_OWN;
                else if (rreq) state_d = RIGHT_OWN;
            end
            LEFT_OWN: begin
                if (lrel)      state_d = rreq ? RIGHT_OWN : FREE;
                else if (rreq) state_d = LEFT_OWN_RPEND;
            end
            LEFT_OWN_RPEND: begin
                if (lrel)      state_d = rrel ? FREE : RIGHT_OWN;
                else if (rrel) state_d = LEFT_OWN;
            end
            RIGHT_OWN: begin
                if (rrel)      state_d = lreq ? LEFT_OWN : FREE;
                else if (lreq) state_d = RIGHT_OWN_LPEND;
            end
            RIGHT_OWN_LPEND: begin
                if (rrel)      state_d = lrel ? FREE : LEFT_OWN;
                else if (lrel) state_d = RIGHT_OWN;
            end
            default:           state_d = FREE;
        endcase
    end

    always_comb begin
        own_l  = 1'b0;
        own_r  = 1'b0;
        pend_l = 1'b0;
        pend_r = 1'b0;
        unique case (state_q)
            FREE:            ;
            LEFT_OWN:        own_l = 1'b1;
            RIGHT_OWN:       own_r = 1'b1;
            LEFT_OWN_RPEND:  begin own_l = 1'b1; pend_r = 1'b1; end
            RIGHT_OWN_LPEND: begin own_r = 1'b1; pend_l = 1'b1; end
            default:         ;
        endcase
    end
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
    parameter int NUM_FLAGS = sem_pkg::SEM_FLAGS,
    localparam int IW = $clog2(NUM_FLAGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lft_sel,
    input  logic [IW-1:0] lft_idx,
    input  logic          lft_wr,
    input  logic          lft_wdata,
    output logic          lft_rdata,
    input  logic          rgt_sel,
    input  logic [IW-1:0] rgt_idx,
    input  logic          rgt_wr,
    input  logic          rgt_wdata,
    output logic          rgt_rdata
);
    logic [NUM_FLAGS-1:0] lreq, lrel, rreq, rrel;
    logic [NUM_FLAGS-1:0] own_l, own_r, pend_l, pend_r;

    sem_port_decode #(.NUM_FLAGS(NUM_FLAGS)) u_dec_l (
        .sel(lft_sel), .idx(lft_idx), .wr(lft_wr), .wdata(lft_wdata),
        .req(lreq), .rel(lrel)
    );

    sem_port_decode #(.NUM_FLAGS(NUM_FLAGS)) u_dec_r (
        .sel(rgt_sel), .idx(rgt_idx), .wr(rgt_wr), .wdata(rgt_wdata),
        .req(rreq), .rel(rrel)
    );

    for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_flag
        sem_flag_cell u_cell (
            .clk(clk), .rst(rst),
            .lreq(lreq[k]), .lrel(lrel[k]), .rreq(rreq[k]), .rrel(rrel[k]),
            .own_l(own_l[k]), .own_r(own_r[k]),
            .pend_l(pend_l[k]), .pend_r(pend_r[k])
        );
    end

    // Active-low ownership read: 0 only for the selected owner.
    assign lft_rdata = !(lft_sel && own_l[lft_idx]);
    assign rgt_rdata = !(rgt_sel && own_r[rgt_idx]);
endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
    parameter int NUM_FLAGS = 8,
    localparam int IW = $clog2(NUM_FLAGS)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 lft_sel,
    input logic [IW-1:0]        lft_idx,
    input logic                 lft_wr,
    input logic                 lft_wdata,
    input logic                 lft_rdata,
    input logic                 rgt_sel,
    input logic [IW-1:0]        rgt_idx,
    input logic                 rgt_wr,
    input logic                 rgt_wdata,
    input logic                 rgt_rdata,
    input logic [NUM_FLAGS-1:0] own_l,
    input logic [NUM_FLAGS-1:0] own_r,
    input logic [NUM_FLAGS-1:0] pend_l,
    input logic [NUM_FLAGS-1:0] pend_r
);
    assert_mutex_R9: assert property (@(posedge clk) disable iff (rst)
        (own_l & own_r) == '0);

    assert_reset_clear_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (own_l == '0 && own_r == '0 && pend_l == '0 && pend_r == '0));

    assert_owner_reads_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (lft_sel && own_l[lft_idx]) |-> !lft_rdata);

    assert_other_reads_one_R3: assert property (@(posedge clk) disable iff (rst)
        (rgt_sel && !own_r[rgt_idx]) |-> rgt_rdata);

    for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_chk
        logic l_q, l_r, r_q, r_r;
        assign l_q = lft_sel && lft_wr && !lft_wdata && lft_idx == IW'(k);
        assign l_r = lft_sel && lft_wr &&  lft_wdata && lft_idx == IW'(k);
        assign r_q = rgt_sel && rgt_wr && !rgt_wdata && rgt_idx == IW'(k);
        assign r_r = rgt_sel && rgt_wr &&  rgt_wdata && rgt_idx == IW'(k);

        assert_keep_left_R5: assert property (@(posedge clk) disable iff (rst)
            (own_l[k] && !l_r) |=> own_l[k]);

        assert_keep_right_R5: assert property (@(posedge clk) disable iff (rst)
            (own_r[k] && !r_r) |=> own_r[k]);

        assert_left_wins_R6: assert property (@(posedge clk) disable iff (rst)
            (!own_l[k] && !own_r[k] && l_q && r_q) |=> (own_l[k] && pend_r[k]));

        assert_handover_R7: assert property (@(posedge clk) disable iff (rst)
            (pend_r[k] && l_r && !r_r) |=> own_r[k]);

        assert_cancel_R8: assert property (@(posedge clk) disable iff (rst)
            (pend_l[k] && l_r) |=> !pend_l[k]);
    end
endmodule

bind sem_bank sem_bank_chk #(.NUM_FLAGS(NUM_FLAGS)) u_chk (
    .clk(clk), .rst(rst),
    .lft_sel(lft_sel), .lft_idx(lft_idx), .lft_wr(lft_wr),
    .lft_wdata(lft_wdata), .lft_rdata(lft_rdata),
    .rgt_sel(rgt_sel), .rgt_idx(rgt_idx), .rgt_wr(rgt_wr),
    .rgt_wdata(rgt_wdata), .rgt_rdata(rgt_rdata),
    .own_l(own_l), .own_r(own_r), .pend_l(pend_l), .pend_r(pend_r)
);

// File: tb/tb_sem_bank.sv
`timescale 1ns/1ps
module tb_sem_bank;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lft_sel = 0, lft_wr = 0, lft_wdata = 0;
    logic [2:0] lft_idx = 0;
    logic       rgt_sel = 0, rgt_wr = 0, rgt_wdata = 0;
    logic [2:0] rgt_idx = 0;
    logic       lft_rdata, rgt_rdata;
    int         n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    sem_bank dut (
        .clk(clk), .rst(rst),
        .lft_sel(lft_sel), .lft_idx(lft_idx), .lft_wr(lft_wr),
        .lft_wdata(lft_wdata), .lft_rdata(lft_rdata),
        .rgt_sel(rgt_sel), .rgt_idx(rgt_idx), .rgt_wr(rgt_wr),
        .rgt_wdata(rgt_wdata), .rgt_rdata(rgt_rdata)
    );

    typedef struct packed {
        logic ls; logic lw; logic ld; logic [2:0] li;
        logic rs; logic rw; logic rd; logic [2:0] ri;
        logic el; logic er;
    } vec_t;

    // Expected read bits reflect the state before this row's write lands.
    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{1,0,0,3'd0, 1,0,0,3'd0, 1,1},   // R3 free reads 1 to both
        '{1,1,0,3'd0, 1,0,0,3'd0, 1,1},   // R2 left requests 0
        '{1,0,0,3'd0, 1,0,0,3'd0, 0,1},   // R2 left owns, R3 right sees 1
        '{1,0,0,3'd0, 1,1,1,3'd0, 0,1},   // R5 right stray release
        '{1,0,0,3'd0, 1,0,0,3'd0, 0,1},   // R5 left still owns
        '{1,0,0,3'd0, 1,1,0,3'd0, 0,1},   // R7 right queues
        '{1,1,1,3'd0, 1,0,0,3'd0, 0,1},   // R7 left releases
        '{1,0,0,3'd0, 1,0,0,3'd0, 1,0},   // R7 right granted
        '{1,1,0,3'd3, 1,1,0,3'd3, 1,1},   // R6 tie on flag 3
        '{1,0,0,3'd3, 1,0,0,3'd3, 0,1},   // R6 left wins
        '{1,1,1,3'd3, 1,0,0,3'd3, 0,1},   // R7 left releases to pending right
        '{1,0,0,3'd3, 1,0,0,3'd3, 1,0},   // R7 right owns 3
        '{1,1,0,3'd3, 1,0,0,3'd3, 1,0},   // R8 left queues
        '{1,1,1,3'd3, 1,0,0,3'd3, 1,0},   // R8 left cancels
        '{1,0,0,3'd3, 1,1,1,3'd3, 1,0},   // R4 right releases
        '{1,0,0,3'd3, 1,0,0,3'd3, 1,1},   // R8 cancelled request not granted
        '{0,1,0,3'd5, 1,0,0,3'd5, 1,1},   // R1 deselected write
        '{1,0,0,3'd5, 1,0,0,3'd5, 1,1},   // R1 flag 5 untouched
        '{1,0,0,3'd0, 1,0,0,3'd0, 1,0}    // R11 flag 0 unaffected by 3 and 5
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic drive(input logic ls, lw, ld, input logic [2:0] li,
                         input logic rs, rw, rd, input logic [2:0] ri);
        @(negedge clk);
        lft_sel = ls; lft_wr = lw; lft_wdata = ld; lft_idx = li;
        rgt_sel = rs; rgt_wr = rw; rgt_wdata = rd; rgt_idx = ri;
        #1;
    endtask

    task automatic pulse_reset();
        drive(0,0,0,3'd0, 0,0,0,3'd0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // R10 reset state: all flags free
        for (int k = 0; k < 8; k++) begin
            drive(1,0,0,3'(k), 1,0,0,3'(k));
            chk("R10 reset left", lft_rdata, 1'b1);
            chk("R10 reset right", rgt_rdata, 1'b1);
        end
        // R1 deselected port reads 1
        drive(0,0,0,3'd0, 0,0,0,3'd0);
        chk("R1 idle left", lft_rdata, 1'b1);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].ls, VEC[i].lw, VEC[i].ld, VEC[i].li,
                  VEC[i].rs, VEC[i].rw, VEC[i].rd, VEC[i].ri);
            chk($sformatf("vec %0d left", i), lft_rdata, VEC[i].el);
            chk($sformatf("vec %0d right", i), rgt_rdata, VEC[i].er);
        end

        // R10 reset frees an owned flag
        pulse_reset();
        drive(1,0,0,3'd0, 1,0,0,3'd0);
        chk("R10 flag0 left", lft_rdata, 1'b1);
        chk("R10 flag0 right", rgt_rdata, 1'b1);

        // R10 reset drops a queued request
        drive(1,1,0,3'd2, 0,0,0,3'd0);
        drive(0,0,0,3'd0, 1,1,0,3'd2);
        pulse_reset();
        drive(1,1,0,3'd2, 0,0,0,3'd0);
        drive(1,1,1,3'd2, 0,0,0,3'd0);
        drive(1,0,0,3'd2, 1,0,0,3'd2);
        chk("R10 pending cleared right", rgt_rdata, 1'b1);
        chk("R10 pending cleared left", lft_rdata, 1'b1);

        // R7 handover from right owner to pending left
        drive(0,0,0,3'd0, 1,1,0,3'd6);
        drive(1,1,0,3'd6, 0,0,0,3'd0);
        drive(1,0,0,3'd6, 1,1,1,3'd6);
        chk("R7 left waits", lft_rdata, 1'b1);
        drive(1,0,0,3'd6, 1,0,0,3'd6);
        chk("R7 left granted", lft_rdata, 1'b0);
        chk("R9 right no longer owns", rgt_rdata, 1'b1);
        drive(1,1,1,3'd6, 0,0,0,3'd0);

        // R11 all flags independent: left takes evens, right takes odds
        for (int k = 0; k < 8; k += 2)
            drive(1,1,0,3'(k), 1,1,0,3'(k+1));
        for (int k = 0; k < 8; k++) begin
            drive(1,0,0,3'(k), 1,0,0,3'(k));
            chk($sformatf("R11 left flag %0d", k), lft_rdata, (k % 2 == 0) ? 1'b0 : 1'b1);
            chk($sformatf("R11 right flag %0d", k), rgt_rdata, (k % 2 == 0) ? 1'b1 : 1'b0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule